// File: doc/BRIEF.md
# Non-Maskable Interrupt Request Controller

This block gathers the interrupt sources of a small 32-bit processor core that no enable bit or mask level may block. Three kinds of event are captured: a falling edge on an active-low external request pin, a watchdog overflow pulse that counts only while the watchdog's count-enable bit is set, and a group of system-error strobes (unaligned access, undefined opcode, other fatal error). Each kind owns one sticky flag in a small status register. The processor reads this register through a simple port, finds the source that fired, and clears the flag by writing a one to its bit. While any flag is set, the block raises a request towards the core and presents the fixed handler address.

The block also sequences start-up. While the active-low reset pin is low, every flag is cleared and the core is held. When the pin is released, a counter waits for the oscillator to settle. The block then gives a one-cycle done pulse together with the reset fetch address and lets the core run. Reset outranks every other function. An assertion of the pin at any time wipes the flags and restarts the whole sequence.

The sequencer is a four-state machine. `SEQ_HOLD` is the state forced while the pin is low (transition T_PIN_LOW, taken from any state). `SEQ_SETTLE` counts the settling cycles and is entered on T_RELEASE, the first clock after the pin goes high. `SEQ_VECTOR` is the single cycle of the done pulse and is entered on T_STABLE, when the count reaches its last value. `SEQ_RUN` is normal operation and is entered on T_START, one cycle later. It is left only through T_PIN_LOW.

Top module: `nmi_source_ctrl`

## Requirements
- R1: While `rst_pin_n` is low, `reg_rdata` is 0, `nmi_req` is 0, `core_hold` is 1, `reset_done` is 0 and `vec_addr` is 0.
- R2: After `rst_pin_n` rises, `reset_done` is high for exactly one cycle. It is seen after the (SETTLE_CYCLES+1)-th rising clock edge. In that cycle `vec_addr` is 0x40000000 and `core_hold` is 0, and `core_hold` stays 0 from then on.
- R3: A high-to-low transition of `ext_nmi_n`, taken through a two-flop synchroniser, sets flag bit 0. If the pin stays low after that flag is cleared, the flag is not set again.
- R4: A `wdt_ovf` pulse sets flag bit 1 only when `wdt_cnt_en` is 1 in the same cycle. When `wdt_cnt_en` is 0 the pulse has no effect.
- R5: Any of `err_unaligned`, `err_undef_op` or `err_fatal` sets flag bit 2.
- R6: `reg_rdata` returns the flags in bit 0 (external), bit 1 (watchdog) and bit 2 (system error). Bits 7..3 read as 0. A flag stays set until software clears it.
- R7: A cycle with `reg_wr` high clears every flag whose bit in `reg_wdata` is 1. Bits written as 0 leave their flags unchanged.
- R8: When a source event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R9: `nmi_req` is high exactly while any flag is set. In `SEQ_RUN`, `vec_addr` is then 0x40000008, and it is 0 when no flag is set.
- R10: Source events that occur before `SEQ_RUN` (during hold, settle or the done cycle) set no flag.
- R11: A low level on `rst_pin_n` during normal operation clears all flags at once, raises `core_hold` and restarts the settle sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_pin_n | input | 1 | Active-low reset pin, asynchronous assertion |
| ext_nmi_n | input | 1 | Active-low external request pin, asynchronous to clk |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| wdt_cnt_en | input | 1 | Watchdog count-enable bit |
| err_unaligned | input | 1 | Unaligned memory access strobe |
| err_undef_op | input | 1 | Undefined instruction strobe |
| err_fatal | input | 1 | Other fatal error strobe |
| reg_wr | input | 1 | Write strobe of the flag register |
| reg_wdata | input | 3 | Write data; a 1 clears the matching flag |
| reg_rdata | output | 8 | Flag register read value |
| nmi_req | output | 1 | Non-maskable request to the core |
| core_hold | output | 1 | Holds the core while reset is pending |
| reset_done | output | 1 | One-cycle pulse when start-up ends |
| vec_addr | output | 32 | Reset or handler fetch address |

## Verification
A source event and a software write-one-to-clear of the same flag can land on the same clock edge. The bench provokes this by pulsing the watchdog overflow with the enable bit, or a system-error strobe, in the very cycle that writes a one to that flag's bit. In one case the flag is already set and in the other it is clear. The flag is judged by reading the register after that edge, where it must read set. The done pulse and a source event can also coincide at the end of settling, so strobes issued before the run state are checked to leave no trace.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

    localparam int unsigned NUM_SRC  = 3;
    localparam int unsigned REG_W    = 8;
    localparam int unsigned ADDR_W   = 32;

    localparam int unsigned BIT_EXT  = 0;
    localparam int unsigned BIT_WDT  = 1;
    localparam int unsigned BIT_ERR  = 2;

    localparam logic [ADDR_W-1:0] RESET_VEC = 32'h4000_0000;
    localparam logic [ADDR_W-1:0] NMI_VEC   = 32'h4000_0008;

    typedef enum logic [1:0] {
        SEQ_HOLD   = 2'd0,
        SEQ_SETTLE = 2'd1,
        SEQ_VECTOR = 2'd2,
        SEQ_RUN    = 2'd3
    } seq_state_t;

endpackage

// File: rtl/nmi_pin_sync.sv
module nmi_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    localparam int unsigned DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= pin_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_comb begin
        fall = chain[DEPTH-1] & ~chain[DEPTH-2];
    end

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R3

endmodule

// File: rtl/nmi_flag_reg.sv
module nmi_flag_reg #(
    parameter int unsigned NUM_SRC = 3,
    parameter int unsigned REG_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic               wr,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] flags,
    output logic [REG_W-1:0]   rdata
);
    localparam int unsigned PAD_W = REG_W - NUM_SRC;

    logic [NUM_SRC-1:0] clr_vec;

    always_comb begin
        clr_vec = wr ? wdata : '0;
    end

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          flags[g] <= 1'b0;
                else if (set_vec[g]) flags[g] <= 1'b1;
                else if (clr_vec[g]) flags[g] <= 1'b0;
            end
        end
    endgenerate

    always_comb begin
        rdata = {{PAD_W{1'b0}}, flags};
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec))); // R8

    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec == '0 && !wr) |=> $stable(flags)); // R6

    AST_CLEAR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec == '0 && wr) |=> ((flags & $past(wdata)) == '0)); // R7

endmodule

// File: rtl/nmi_reset_seq.sv
module nmi_reset_seq
    import nmi_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    output seq_state_t state,
    output logic       run,
    output logic       core_hold,
    output logic       reset_done
);
    localparam int unsigned CNT_W = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    seq_state_t       nxt;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            SEQ_HOLD:   nxt = SEQ_SETTLE;
            SEQ_SETTLE: if (cnt == LAST) nxt = SEQ_VECTOR;
            SEQ_VECTOR: nxt = SEQ_RUN;
            SEQ_RUN:    nxt = SEQ_RUN;
            default:    nxt = SEQ_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_HOLD;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (state == SEQ_SETTLE) cnt <= cnt + 1'b1;
        else                         cnt <= '0;
    end

    always_comb begin
        run        = 1'b0;
        core_hold  = 1'b0;
        reset_done = 1'b0;
        unique case (state)
            SEQ_HOLD:   core_hold  = 1'b1;
            SEQ_SETTLE: core_hold  = 1'b1;
            SEQ_VECTOR: reset_done = 1'b1;
            SEQ_RUN:    run        = 1'b1;
            default:    core_hold  = 1'b1;
        endcase
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_done |=> !reset_done); // R2

    AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_hold) |-> reset_done); // R2

    AST_RUN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> run); // R2

endmodule

// File: rtl/nmi_source_ctrl.sv
module nmi_source_ctrl
    import nmi_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 1024,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_pin_n,
    input  logic              ext_nmi_n,
    input  logic              wdt_ovf,
    input  logic              wdt_cnt_en,
    input  logic              err_unaligned,
    input  logic              err_undef_op,
    input  logic              err_fatal,
    input  logic              reg_wr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              nmi_req,
    output logic              core_hold,
    output logic              reset_done,
    output logic [ADDR_W-1:0] vec_addr
);
    seq_state_t         state;
    logic               run;
    logic               ext_fall;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] flags;

    nmi_reset_seq #(
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_pin_n),
        .state      (state),
        .run        (run),
        .core_hold  (core_hold),
        .reset_done (reset_done)
    );

    nmi_pin_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_pin_n),
        .pin_n (ext_nmi_n),
        .fall  (ext_fall)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[BIT_EXT] = run & ext_fall;
        set_vec[BIT_WDT] = run & wdt_ovf & wdt_cnt_en;
        set_vec[BIT_ERR] = run & (err_unaligned | err_undef_op | err_fatal);
    end

    nmi_flag_reg #(
        .NUM_SRC (NUM_SRC),
        .REG_W   (REG_W)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_pin_n),
        .set_vec (set_vec),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .flags   (flags),
        .rdata   (reg_rdata)
    );

    always_comb begin
        nmi_req  = |flags;
        vec_addr = '0;
        unique case (state)
            SEQ_VECTOR: vec_addr = RESET_VEC;
            SEQ_RUN:    if (nmi_req) vec_addr = NMI_VEC;
            default:    vec_addr = '0;
        endcase
    end

    AST_WDT_GATED: assert property (@(posedge clk) disable iff (!rst_pin_n)
        $rose(reg_rdata[BIT_WDT]) |-> $past(wdt_ovf && wdt_cnt_en)); // R4

    AST_QUIET_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_pin_n)
        core_hold |-> (reg_rdata == '0)); // R10

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_pin_n)
        $rose(reg_rdata[BIT_ERR]) |-> $past(err_unaligned || err_undef_op || err_fatal)); // R5

endmodule

// File: tb/nmi_source_ctrl_test.sv
`timescale 1ns/1ps
module nmi_source_ctrl_test;

    localparam int unsigned SETTLE = 1024;
    localparam int unsigned NVEC   = 17;

    logic        clk = 1'b0;
    logic        rst_pin_n = 1'b0;
    logic        ext_nmi_n = 1'b1;
    logic        wdt_ovf = 1'b0;
    logic        wdt_cnt_en = 1'b0;
    logic        err_unaligned = 1'b0;
    logic        err_undef_op = 1'b0;
    logic        err_fatal = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_wdata = 3'b000;
    logic [7:0]  reg_rdata;
    logic        nmi_req;
    logic        core_hold;
    logic        reset_done;
    logic [31:0] vec_addr;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    nmi_source_ctrl #(.SETTLE_CYCLES(SETTLE)) uut (
        .clk(clk), .rst_pin_n(rst_pin_n), .ext_nmi_n(ext_nmi_n),
        .wdt_ovf(wdt_ovf), .wdt_cnt_en(wdt_cnt_en),
        .err_unaligned(err_unaligned), .err_undef_op(err_undef_op),
        .err_fatal(err_fatal), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .nmi_req(nmi_req), .core_hold(core_hold),
        .reset_done(reset_done), .vec_addr(vec_addr)
    );

    // fields: [12] ext_n [11] ovf [10] cnt_en [9] unaligned [8] undef_op
    //         [7] fatal [6] wr [5:3] wdata [2:0] expected flags
    localparam logic [12:0] VEC [NVEC] = '{
        13'b1_0_0_0_0_0_1_111_000, // R7 clear all, nothing set
        13'b1_1_0_0_0_0_0_000_000, // R4 overflow without enable
        13'b1_1_1_0_0_0_0_000_010, // R4 overflow with enable
        13'b1_0_0_1_0_0_0_000_110, // R5 unaligned
        13'b1_0_0_0_0_0_1_010_100, // R7 clear watchdog only
        13'b1_0_0_0_0_0_1_100_000, // R7 clear error
        13'b1_0_0_0_1_0_0_000_100, // R5 undefined op
        13'b1_0_0_0_0_0_1_100_000, // R7
        13'b1_0_0_0_0_1_0_000_100, // R5 fatal
        13'b1_0_0_0_0_0_1_100_000, // R7
        13'b0_0_0_0_0_0_0_000_001, // R3 pin falls
        13'b0_0_0_0_0_0_1_001_000, // R3 clear while pin held low
        13'b0_0_0_0_0_0_0_000_000, // R3 still low, no re-set
        13'b1_0_0_0_0_0_0_000_000, // R3 pin returns high
        13'b1_1_1_0_0_0_0_000_010, // R6 watchdog sticky
        13'b1_0_0_0_0_0_1_000_010, // R7 write of zero keeps flag
        13'b1_0_0_0_0_0_1_010_000  // R7
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wdt_ovf = 1'b0; wdt_cnt_en = 1'b0; err_unaligned = 1'b0;
        err_undef_op = 1'b0; err_fatal = 1'b0; reg_wr = 1'b0; reg_wdata = 3'b000;
    endtask

    task automatic release_and_count(input string tag);
        int n = 0;
        @(negedge clk);
        rst_pin_n = 1'b1;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 5) begin // R10 events during settle
                wdt_ovf = 1'b1; wdt_cnt_en = 1'b1; err_fatal = 1'b1; ext_nmi_n = 1'b0;
            end else if (n == 6) begin
                idle_inputs();
                ext_nmi_n = 1'b1;
            end
            if (reset_done || n > SETTLE + 10) break;
        end
        check({tag, " R2 settle length"}, n, SETTLE + 1);
        check({tag, " R2 reset vector"}, vec_addr, 32'h4000_0000);
        check({tag, " R2 hold released"}, {31'd0, core_hold}, 32'd0);
        @(negedge clk);
        check({tag, " R2 done one cycle"}, {31'd0, reset_done}, 32'd0);
        check({tag, " R10 no flags from pre-run events"}, {24'd0, reg_rdata}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [12:0] v;
        repeat (3) @(negedge clk);
        check("R1 flags in reset", {24'd0, reg_rdata}, 32'd0);
        check("R1 req in reset", {31'd0, nmi_req}, 32'd0);
        check("R1 hold in reset", {31'd0, core_hold}, 32'd1);
        check("R1 done in reset", {31'd0, reset_done}, 32'd0);
        check("R1 vec in reset", vec_addr, 32'd0);

        release_and_count("start");

        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            @(negedge clk);
            ext_nmi_n = v[12]; wdt_ovf = v[11]; wdt_cnt_en = v[10];
            err_unaligned = v[9]; err_undef_op = v[8]; err_fatal = v[7];
            reg_wr = v[6]; reg_wdata = v[5:3];
            @(negedge clk);
            idle_inputs();
            repeat (4) @(negedge clk);
            check($sformatf("R6 vector %0d flags", i), {24'd0, reg_rdata}, {29'd0, v[2:0]});
            check($sformatf("R9 vector %0d req", i), {31'd0, nmi_req}, {31'd0, |v[2:0]});
            check($sformatf("R9 vector %0d addr", i), vec_addr,
                  (|v[2:0]) ? 32'h4000_0008 : 32'd0);
        end

        // R8: flag already set, set and clear same cycle
        @(negedge clk);
        wdt_ovf = 1'b1; wdt_cnt_en = 1'b1;
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
        wdt_ovf = 1'b1; wdt_cnt_en = 1'b1; reg_wr = 1'b1; reg_wdata = 3'b010;
        @(negedge clk);
        idle_inputs();
        check("R8 set beats clear (was set)", {24'd0, reg_rdata}, 32'h02);
        // R8: flag clear, set and clear same cycle
        err_unaligned = 1'b1; reg_wr = 1'b1; reg_wdata = 3'b100;
        @(negedge clk);
        idle_inputs();
        check("R8 set beats clear (was clear)", {24'd0, reg_rdata}, 32'h06);

        // R11: reset mid-run
        @(negedge clk);
        rst_pin_n = 1'b0;
        #1;
        check("R11 flags wiped", {24'd0, reg_rdata}, 32'd0);
        check("R11 hold raised", {31'd0, core_hold}, 32'd1);
        check("R11 req dropped", {31'd0, nmi_req}, 32'd0);
        repeat (3) @(negedge clk);
        release_and_count("restart R11");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule